// File: doc/BRIEF.md
# Serial Motor Command Frame Receiver

This block takes a command frame from a three-wire serial link and turns it into the control registers of a multi-channel motor driver. The three wires are a bit clock, a data line and a latch strobe. The pins are brought into the system clock domain through a synchronizer. A data bit is taken on every rising edge of the bit clock. A frame is 64 bits long: eight bytes, each sent least significant bit first, with the first byte sent first.

The top three bits of the first byte are a header, and the header picks which register set the frame writes. An initialization frame carries the two start-up wait times. A standard frame carries the channel direction, the channel enable, the pulse-count code and the 15-bit pulse period. Both kinds of frame carry the four expansion-port controls.

Nothing changes until the latch strobe arrives, and the strobe only commits a frame that is exactly 64 bits long. A frame with a bad header, a set reserved bit, or a zero in a field that must be nonzero is dropped and sets a sticky error flag. Pulse generation and the output stages sit downstream of this block.

Top module: `mcr_cmd_rx`

## Requirements
- R1: While reset is high and after it is released, the expansion outputs read all ones (high impedance), frame_err_o is 0, and every other output register is 0.
- R2: Stream bit n is sampled on a rising edge of ser_clk_i and lands in byte n/8, bit n%8 (LSB first, byte 1 first). Frame bit positions below count from bit 0 of byte 1.
- R3: A frame whose byte 1 bits 7..5 are 111 is an initialization frame. On commit it loads start_wait_o from byte 2 and drive_wait_o from byte 3, and leaves the standard-frame outputs unchanged.
- R4: A frame whose byte 1 bits 7..5 are 000 is a standard frame. On commit it loads ch_dir_o from byte 2 bit 7, ch_en_o from byte 2 bit 6, pulse_code_o from byte 2 bits 5..0, and pulse_per_o from byte 4 bits 6..0 (upper) above byte 3 (lower). Byte 4 bit 7 is ignored. The initialization outputs are left unchanged.
- R5: Every committed frame copies byte 1 bits 3..0 to exp_hiz_o[3:0]; a 1 means high impedance and a 0 means current sink. Byte 1 bit 4 must be 0.
- R6: The outputs change only in response to a rising edge of ser_lat_i that follows exactly 64 bits. Sending 64 bits without a strobe changes nothing.
- R7: An initialization frame with a zero start wait or a zero drive wait, or a standard frame whose 15-bit period is zero, is dropped and sets frame_err_o.
- R8: A header other than 111 or 000, or byte 1 bit 4 set, drops the frame and sets frame_err_o. Once set, frame_err_o stays 1 until reset, and later good frames still commit.
- R9: A strobe that ends a frame shorter or longer than 64 bits discards the frame without changing any output, including frame_err_o. The bit count restarts at zero after every strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial bit clock, asynchronous to clk |
| ser_dat_i | input | 1 | Serial data |
| ser_lat_i | input | 1 | Frame latch strobe, rising edge commits |
| exp_hiz_o | output | NUM_EXP (4) | Expansion port controls, 1 = high impedance, 0 = sink |
| ch_dir_o | output | 1 | Channel rotation direction |
| ch_en_o | output | 1 | Channel enable |
| pulse_code_o | output | PCNT_W (6) | Pulse-count code; the pulse count is the code times two |
| pulse_per_o | output | PER_W (15) | Pulse period in quarter-microsecond units |
| start_wait_o | output | BYTE_W (8) | Start-point wait |
| drive_wait_o | output | BYTE_W (8) | Start-point drive wait |
| frame_err_o | output | 1 | Sticky error on a dropped frame |

## Verification
The bench uses the default parameters: a 64-bit frame, a two-stage synchronizer, a 6-bit pulse code and a 15-bit period. With these widths, every header value, the ignored top bit of byte 4 and the all-ones pulse code are reachable with literal frames. The short link delay means each strobe can be followed by a check a few cycles later. It also means the 40-bit, 64-bit-without-strobe and 72-bit cases show whether the counter restarts after every strobe.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  localparam int HDR_W = 3;

  typedef enum logic [1:0] {
    FR_NONE = 2'd0,
    FR_INIT = 2'd1,
    FR_STD  = 2'd2
  } frame_kind_e;
endpackage

// File: rtl/mcr_sync.sv
module mcr_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] level_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign level_o = stg_q[STAGES-1];
endmodule

// File: rtl/mcr_shift.sv
module mcr_shift #(
  parameter int FRAME_BITS = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  shift_i,
  input  logic                  bit_i,
  input  logic                  clear_i,
  output logic [FRAME_BITS-1:0] frame_o,
  output logic                  full_o
);
  localparam int CNT_W   = $clog2(FRAME_BITS + 2);
  localparam int CNT_MAX = FRAME_BITS + 1;

  logic [CNT_W-1:0]      cnt_q;
  logic [FRAME_BITS-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (shift_i) begin
      sr_q <= {bit_i, sr_q[FRAME_BITS-1:1]};
      if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign frame_o = sr_q;
  assign full_o  = (cnt_q == CNT_W'(FRAME_BITS));

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(CNT_MAX)); // R9
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (cnt_q == '0)); // R9
endmodule

// File: rtl/mcr_decode.sv
module mcr_decode
  import mcr_pkg::*;
#(
  parameter int FRAME_BITS = 64,
  parameter int BYTE_W     = 8,
  parameter int NUM_EXP    = 4,
  parameter int PCNT_W     = 6,
  parameter int PER_W      = 15,
  parameter logic [HDR_W-1:0] HDR_INIT = 3'b111,
  parameter logic [HDR_W-1:0] HDR_STD  = 3'b000
) (
  input  logic [FRAME_BITS-1:0] frame_i,
  output frame_kind_e           kind_o,
  output logic                  ok_o,
  output logic [NUM_EXP-1:0]    exp_o,
  output logic                  dir_o,
  output logic                  en_o,
  output logic [PCNT_W-1:0]     code_o,
  output logic [PER_W-1:0]      per_o,
  output logic [BYTE_W-1:0]     sw_o,
  output logic [BYTE_W-1:0]     dw_o
);
  localparam int B2_LSB = BYTE_W;
  localparam int B3_LSB = 2 * BYTE_W;
  localparam int B4_LSB = 3 * BYTE_W;
  localparam int PER_HI = PER_W - BYTE_W;
  localparam int USED   = B4_LSB + PER_HI;
  localparam int RSV    = BYTE_W - HDR_W - 1;

  logic [HDR_W-1:0]  hdr;
  logic [BYTE_W-1:0] b2, b3;
  logic              rsv_bit;
  logic              unused_hi;

  assign hdr     = frame_i[BYTE_W-1 -: HDR_W];
  assign rsv_bit = frame_i[RSV];
  assign b2      = frame_i[B2_LSB +: BYTE_W];
  assign b3      = frame_i[B3_LSB +: BYTE_W];
  assign unused_hi = ^frame_i[FRAME_BITS-1:USED];

  assign exp_o  = frame_i[NUM_EXP-1:0];
  assign dir_o  = b2[BYTE_W-1];
  assign en_o   = b2[BYTE_W-2];
  assign code_o = b2[PCNT_W-1:0];
  assign per_o  = {frame_i[B4_LSB +: PER_HI], b3};
  assign sw_o   = b2;
  assign dw_o   = b3;

  always_comb begin
    if (hdr == HDR_INIT)     kind_o = FR_INIT;
    else if (hdr == HDR_STD) kind_o = FR_STD;
    else                     kind_o = FR_NONE;
  end

  always_comb begin
    ok_o = 1'b0;
    if (!rsv_bit) begin
      case (kind_o)
        FR_INIT: ok_o = (|b2) && (|b3);
        FR_STD:  ok_o = |per_o;
        default: ok_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/mcr_cmd_rx.sv
module mcr_cmd_rx
  import mcr_pkg::*;
#(
  parameter int FRAME_BYTES = 8,
  parameter int BYTE_W      = 8,
  parameter int NUM_EXP     = 4,
  parameter int PCNT_W      = 6,
  parameter int PER_W       = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ser_clk_i,
  input  logic               ser_dat_i,
  input  logic               ser_lat_i,
  output logic [NUM_EXP-1:0] exp_hiz_o,
  output logic               ch_dir_o,
  output logic               ch_en_o,
  output logic [PCNT_W-1:0]  pulse_code_o,
  output logic [PER_W-1:0]   pulse_per_o,
  output logic [BYTE_W-1:0]  start_wait_o,
  output logic [BYTE_W-1:0]  drive_wait_o,
  output logic               frame_err_o
);
  localparam int FRAME_BITS = FRAME_BYTES * BYTE_W;

  logic [2:0] pins_s;
  logic       sclk_prev_q, lat_prev_q;
  logic       bit_rise, lat_rise;

  mcr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rst     (rst),
    .async_i ({ser_lat_i, ser_dat_i, ser_clk_i}),
    .level_o (pins_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev_q <= 1'b0;
      lat_prev_q  <= 1'b0;
    end else begin
      sclk_prev_q <= pins_s[0];
      lat_prev_q  <= pins_s[2];
    end
  end

  assign bit_rise = pins_s[0] & ~sclk_prev_q;
  assign lat_rise = pins_s[2] & ~lat_prev_q;

  logic [FRAME_BITS-1:0] frame;
  logic                  full;

  mcr_shift #(.FRAME_BITS(FRAME_BITS)) shift_i (
    .clk     (clk),
    .rst     (rst),
    .shift_i (bit_rise),
    .bit_i   (pins_s[1]),
    .clear_i (lat_rise),
    .frame_o (frame),
    .full_o  (full)
  );

  frame_kind_e          kind;
  logic                 ok;
  logic [NUM_EXP-1:0]   d_exp;
  logic                 d_dir, d_en;
  logic [PCNT_W-1:0]    d_code;
  logic [PER_W-1:0]     d_per;
  logic [BYTE_W-1:0]    d_sw, d_dw;

  mcr_decode #(
    .FRAME_BITS (FRAME_BITS),
    .BYTE_W     (BYTE_W),
    .NUM_EXP    (NUM_EXP),
    .PCNT_W     (PCNT_W),
    .PER_W      (PER_W)
  ) dec_i (
    .frame_i (frame),
    .kind_o  (kind),
    .ok_o    (ok),
    .exp_o   (d_exp),
    .dir_o   (d_dir),
    .en_o    (d_en),
    .code_o  (d_code),
    .per_o   (d_per),
    .sw_o    (d_sw),
    .dw_o    (d_dw)
  );

  logic commit;
  assign commit = lat_rise & full;

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_hiz_o    <= '1;
      ch_dir_o     <= 1'b0;
      ch_en_o      <= 1'b0;
      pulse_code_o <= '0;
      pulse_per_o  <= '0;
      start_wait_o <= '0;
      drive_wait_o <= '0;
      frame_err_o  <= 1'b0;
    end else if (commit) begin
      if (ok) begin
        exp_hiz_o <= d_exp;
        if (kind == FR_INIT) begin
          start_wait_o <= d_sw;
          drive_wait_o <= d_dw;
        end else begin
          ch_dir_o     <= d_dir;
          ch_en_o      <= d_en;
          pulse_code_o <= d_code;
          pulse_per_o  <= d_per;
        end
      end else begin
        frame_err_o <= 1'b1;
      end
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(exp_hiz_o) && $stable(pulse_per_o) && $stable(start_wait_o) && $stable(ch_en_o)); // R6
  AST_PARTIAL_KEEP: assert property (@(posedge clk) disable iff (rst)
    (lat_rise && !full) |=> $stable(frame_err_o) && $stable(drive_wait_o)); // R9
  AST_BAD_DROP: assert property (@(posedge clk) disable iff (rst)
    (commit && !ok) |=> frame_err_o && $stable(exp_hiz_o) && $stable(pulse_per_o) && $stable(start_wait_o)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    frame_err_o |=> frame_err_o); // R8
  AST_INIT_KEEPS_STD: assert property (@(posedge clk) disable iff (rst)
    (commit && ok && kind == FR_INIT) |=> $stable(pulse_per_o) && $stable(pulse_code_o) && $stable(ch_en_o)); // R3
  AST_STD_KEEPS_INIT: assert property (@(posedge clk) disable iff (rst)
    (commit && ok && kind == FR_STD) |=> $stable(start_wait_o) && $stable(drive_wait_o)); // R4
  AST_EXP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (commit && ok) |=> exp_hiz_o == $past(d_exp)); // R5
endmodule

// File: tb/mcr_cmd_rx_tb_top.sv
module mcr_cmd_rx_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_lat = 1'b0;
  logic [3:0]  exp_hiz_o;
  logic        ch_dir_o, ch_en_o, frame_err_o;
  logic [5:0]  pulse_code_o;
  logic [14:0] pulse_per_o;
  logic [7:0]  start_wait_o, drive_wait_o;

  always #10 clk = ~clk;

  mcr_cmd_rx dut_i (
    .clk (clk), .rst (rst),
    .ser_clk_i (ser_clk), .ser_dat_i (ser_dat), .ser_lat_i (ser_lat),
    .exp_hiz_o (exp_hiz_o), .ch_dir_o (ch_dir_o), .ch_en_o (ch_en_o),
    .pulse_code_o (pulse_code_o), .pulse_per_o (pulse_per_o),
    .start_wait_o (start_wait_o), .drive_wait_o (drive_wait_o),
    .frame_err_o (frame_err_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Model state, from the requirements
  logic [3:0]  m_exp;
  logic        m_dir, m_en, m_err;
  logic [5:0]  m_code;
  logic [14:0] m_per;
  logic [7:0]  m_sw, m_dw;

  // {accept flag, frame}; frame bits [7:0] = byte 1, [15:8] = byte 2, ...
  localparam int NV = 10;
  localparam logic [64:0] VEC [NV] = '{
    {1'b1, 64'hA5C30F96_77_22_10_E5},  // init ok
    {1'b1, 64'hA5C30F96_12_34_C5_0A},  // std ok
    {1'b1, 64'hA5C30F96_92_FF_3F_03},  // std ok, byte4 bit7 ignored
    {1'b0, 64'hA5C30F96_00_40_00_E0},  // init, start wait zero
    {1'b0, 64'hA5C30F96_00_00_33_E0},  // init, drive wait zero
    {1'b0, 64'hA5C30F96_80_00_41_00},  // std, period zero
    {1'b0, 64'hA5C30F96_01_11_41_A0},  // header 101
    {1'b0, 64'hA5C30F96_01_11_41_10},  // reserved bit set
    {1'b1, 64'hA5C30F96_00_01_81_0F},  // std ok after errors, period 1
    {1'b1, 64'hA5C30F96_00_FF_01_E6}   // init ok, minimum wait
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp_v);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R5 exp_hiz"},   32'(exp_hiz_o),    32'(m_exp));
    chk({tag, " R4 dir"},       32'(ch_dir_o),     32'(m_dir));
    chk({tag, " R4 en"},        32'(ch_en_o),      32'(m_en));
    chk({tag, " R4 code"},      32'(pulse_code_o), 32'(m_code));
    chk({tag, " R4 period"},    32'(pulse_per_o),  32'(m_per));
    chk({tag, " R3 start_wait"},32'(start_wait_o), 32'(m_sw));
    chk({tag, " R3 drive_wait"},32'(drive_wait_o), 32'(m_dw));
    chk({tag, " R8 err"},       32'(frame_err_o),  32'(m_err));
  endtask

  task automatic model_reset();
    m_exp = 4'hF; m_dir = 0; m_en = 0; m_code = 0; m_per = 0;
    m_sw = 0; m_dw = 0; m_err = 0;
  endtask

  task automatic model_commit(input logic [63:0] f, input logic good);
    if (good) begin
      m_exp = f[3:0];
      if (f[7:5] == 3'b111) begin
        m_sw = f[15:8];
        m_dw = f[23:16];
      end else begin
        m_dir = f[15]; m_en = f[14]; m_code = f[13:8];
        m_per = {f[30:24], f[23:16]};
      end
    end else begin
      m_err = 1'b1;
    end
  endtask

  // R2: bit n of the stream is frame bit n (LSB of byte 1 first)
  task automatic send_bits(input logic [63:0] f, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ser_dat = f[i % 64];
      repeat (4) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic strobe();
    @(negedge clk) ser_lat = 1'b1;
    repeat (4) @(negedge clk);
    ser_lat = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (5) @(negedge clk);
    chk("R1 exp_hiz in reset", 32'(exp_hiz_o), 32'hF);
    chk("R1 err in reset", 32'(frame_err_o), 32'h0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check_all("R1 after reset");

    for (int v = 0; v < NV; v++) begin
      send_bits(VEC[v][63:0], 64);
      strobe();
      model_commit(VEC[v][63:0], VEC[v][64]);
      check_all($sformatf("R2 vec%0d %s", v, VEC[v][64] ? "accept" : "R7 drop"));
    end

    // R9: 40-bit partial frame, then strobe: nothing changes
    send_bits(64'hA5C30F96_05_06_07_E3, 40);
    strobe();
    check_all("R9 partial");
    // counter restarted: next full frame commits
    send_bits(64'hA5C30F96_05_06_07_E3, 64);
    strobe();
    model_commit(64'hA5C30F96_05_06_07_E3, 1'b1);
    check_all("R9 restart");

    // R6: 64 bits without strobe leaves outputs alone
    send_bits(64'hA5C30F96_7F_FE_55_05, 64);
    check_all("R6 no strobe");
    strobe();
    model_commit(64'hA5C30F96_7F_FE_55_05, 1'b1);
    check_all("R6 strobe commits");

    // R9: 72-bit overlong frame is discarded
    send_bits(64'hA5C30F96_01_02_C0_00, 72);
    strobe();
    check_all("R9 overlong");

    // R8: error only clears with reset (R1)
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    model_reset();
    check_all("R1 R8 re-reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule